// File: doc/BRIEF.md
# UART Banked Enhanced-Register Gate

This block is the register front end of one 16550-style UART channel. A host reaches it over a 3-bit register address, an 8-bit write bus, a registered 8-bit read bus and single-cycle read and write strobes. The block holds six registers: the line control value, the feature register, and four flow-control characters (two resume, two pause). It also holds the interrupt enable, FIFO control and modem control registers, which have extended upper bits.

The line control value picks the address map. When it holds the unlock key 0xBF, addresses 2 and 4..7 reach the feature register and the four flow characters. For any other value the normal map is active. In the normal map, address 1 is the interrupt enable register. Address 2 writes FIFO control and reads the interrupt status supplied by a neighbour. Address 4 is modem control. Line control stays at address 3 in both maps, so the host can always get back out of the enhanced map.

Feature bit 4 unlocks the extended bits of the ordinary registers. While it is 0, writes leave those bits as they were, and status reads return them as 0. The remaining feature bits are exported as mode enables for the flow-control logic. Access is plain strobed register traffic. There is no valid/ready handshake and no back-pressure: every strobe completes in the cycle it is seen.

Top module: `uart_enh_regfile`

## Requirements
- R1: After reset, line control, feature, interrupt enable, FIFO control, modem control and all four flow characters are 0x00, and the read bus is 0x00.
- R2: The enhanced map is active only while line control equals exactly 0xBF. A value such as 0xBE selects the normal map.
- R3: In the enhanced map, feature is at address 2, XON1 at 4, XON2 at 5, XOFF1 at 6 and XOFF2 at 7. All are 8-bit read/write. Read data appears on the read bus in the cycle after the read strobe and holds until the next read.
- R4: Line control is read/write at address 3 in both maps.
- R5: Writes made in the normal map never change any flow character. A write to address 2 in the normal map goes to FIFO control, not to the feature register.
- R6: Feature bits are exported as follows: bit 7 is auto-CTS enable, bit 6 is auto-RTS enable, bit 5 is special-character enable, bit 4 is extended unlock, and bits 3:0 are the software flow mode, unchanged.
- R7: The interrupt enable register is at normal address 1 and is readable. While feature bit 4 is 0, its bits 7:4 keep their value on a write.
- R8: FIFO control is write-only at normal address 2 and is exported. While feature bit 4 is 0, its bits 5:4 keep their value on a write.
- R9: Modem control is read/write at normal address 4. While feature bit 4 is 0, its bits 7:5 keep their value on a write.
- R10: A read of normal address 2 returns the interrupt-status input. While feature bit 4 is 0, bits 5:4 of that value are forced to 0.
- R11: Addresses 0 and 1 in the enhanced map, and addresses 0, 5, 6 and 7 in the normal map, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe; data appears on the next cycle |
| reg_rdata | output | 8 | Registered read data |
| isr_in | input | 8 | Interrupt status from the interrupt logic |
| lcr_o | output | 8 | Line control value |
| ier_o | output | 8 | Interrupt enable value |
| fcr_o | output | 8 | FIFO control value |
| mcr_o | output | 8 | Modem control value |
| xon1_o | output | 8 | First resume character |
| xon2_o | output | 8 | Second resume character |
| xoff1_o | output | 8 | First pause character |
| xoff2_o | output | 8 | Second pause character |
| auto_cts_en | output | 1 | Automatic CTS flow enable |
| auto_rts_en | output | 1 | Automatic RTS flow enable |
| spec_char_en | output | 1 | Special-character detect enable |
| ext_unlock | output | 1 | Extended-bit unlock |
| sw_flow_mode | output | 4 | Software flow-control mode |

## Verification
The bench builds the block with its defaults: 8-bit data, unlock key 0xBF, and the extended-bit masks 0xF0, 0x30, 0xE0 and 0x30. With these values, every gated bit of every ordinary register can be observed on its export port, both locked and unlocked. Directed sequences cover the near-miss key 0xBE, writes to shared addresses in each map, and relocking after unlock. Random traffic is biased towards the key, so both maps are entered and left many times while a behavioural model is compared every cycle.

// File: rtl/uart_enh_pkg.sv
package uart_enh_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLOW  = 4;

  localparam logic [ADDR_W-1:0] A_IER    = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2; // FCR write / ISR read, or feature reg
  localparam logic [ADDR_W-1:0] A_LINE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODEM  = 3'd4;

  typedef struct packed {
    logic             enh;
    logic             wr_line;
    logic             wr_feat;
    logic             wr_ier;
    logic             wr_fcr;
    logic             wr_mcr;
    logic [NFLOW-1:0] wr_flow;
  } acc_dec_t;
endpackage

// File: rtl/uart_enh_decode.sv
module uart_enh_decode
  import uart_enh_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY = 8'hBF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     line_q,
  output acc_dec_t          dec
);
  logic enh;
  assign enh = (line_q == KEY);

  always_comb begin
    dec.enh     = enh;
    dec.wr_line = wr && (addr == A_LINE);
    dec.wr_feat = wr && enh && (addr == A_STATUS);
    dec.wr_ier  = wr && !enh && (addr == A_IER);
    dec.wr_fcr  = wr && !enh && (addr == A_STATUS);
    dec.wr_mcr  = wr && !enh && (addr == A_MODEM);
  end

  for (genvar i = 0; i < NFLOW; i++) begin : g_flow_dec
    assign dec.wr_flow[i] = wr && enh && (addr == ADDR_W'(NFLOW + i));
  end
endmodule

// File: rtl/uart_enh_lockreg.sv
module uart_enh_lockreg #(
  parameter int DW = 8,
  parameter logic [DW-1:0] XMASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          unlock,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] keep;
  assign keep = unlock ? '0 : XMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q <= (d & ~keep) | (q & keep);
  end

  // gated bits hold while locked (R7, R8, R9 per instance)
  assert_locked_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlock) |=> ((q & XMASK) == ($past(q) & XMASK)));
endmodule

// File: rtl/uart_enh_flowregs.sv
module uart_enh_flowregs
  import uart_enh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NFLOW-1:0]          we,
  input  logic [DW-1:0]             d,
  output logic [NFLOW-1:0][DW-1:0]  q
);
  for (genvar i = 0; i < NFLOW; i++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else if (we[i]) q[i] <= d;
    end
  end

  assert_one_flow_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
endmodule

// File: rtl/uart_enh_regfile.sv
module uart_enh_regfile
  import uart_enh_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY       = 8'hBF,
  parameter logic [DW-1:0] IER_XMASK = 8'hF0,
  parameter logic [DW-1:0] FCR_XMASK = 8'h30,
  parameter logic [DW-1:0] MCR_XMASK = 8'hE0,
  parameter logic [DW-1:0] ISR_XMASK = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     isr_in,
  output logic [DW-1:0]     lcr_o,
  output logic [DW-1:0]     ier_o,
  output logic [DW-1:0]     fcr_o,
  output logic [DW-1:0]     mcr_o,
  output logic [DW-1:0]     xon1_o,
  output logic [DW-1:0]     xon2_o,
  output logic [DW-1:0]     xoff1_o,
  output logic [DW-1:0]     xoff2_o,
  output logic              auto_cts_en,
  output logic              auto_rts_en,
  output logic              spec_char_en,
  output logic              ext_unlock,
  output logic [3:0]        sw_flow_mode
);
  acc_dec_t                  dec;
  logic [DW-1:0]             line_q, feat_q, ier_q, fcr_q, mcr_q;
  logic [NFLOW-1:0][DW-1:0]  flow_q;
  logic                      unlock;
  logic [DW-1:0]             rd_mux;

  assign unlock = feat_q[4];

  uart_enh_decode #(.DW(DW), .KEY(KEY)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .line_q(line_q), .dec(dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      feat_q <= '0;
    end else begin
      if (dec.wr_line) line_q <= reg_wdata;
      if (dec.wr_feat) feat_q <= reg_wdata;
    end
  end

  uart_enh_lockreg #(.DW(DW), .XMASK(IER_XMASK)) u_ier (
    .clk(clk), .rst_n(rst_n), .we(dec.wr_ier), .unlock(unlock), .d(reg_wdata), .q(ier_q));
  uart_enh_lockreg #(.DW(DW), .XMASK(FCR_XMASK)) u_fcr (
    .clk(clk), .rst_n(rst_n), .we(dec.wr_fcr), .unlock(unlock), .d(reg_wdata), .q(fcr_q));
  uart_enh_lockreg #(.DW(DW), .XMASK(MCR_XMASK)) u_mcr (
    .clk(clk), .rst_n(rst_n), .we(dec.wr_mcr), .unlock(unlock), .d(reg_wdata), .q(mcr_q));

  uart_enh_flowregs #(.DW(DW)) u_flow (
    .clk(clk), .rst_n(rst_n), .we(dec.wr_flow), .d(reg_wdata), .q(flow_q));

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_LINE) rd_mux = line_q;
    else if (dec.enh) begin
      if (reg_addr == A_STATUS) rd_mux = feat_q;
      else if (reg_addr[ADDR_W-1]) rd_mux = flow_q[reg_addr[ADDR_W-2:0]];
    end else begin
      case (reg_addr)
        A_IER:    rd_mux = ier_q;
        A_STATUS: rd_mux = unlock ? isr_in : (isr_in & ~ISR_XMASK);
        A_MODEM:  rd_mux = mcr_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign lcr_o        = line_q;
  assign ier_o        = ier_q;
  assign fcr_o        = fcr_q;
  assign mcr_o        = mcr_q;
  assign xon1_o       = flow_q[0];
  assign xon2_o       = flow_q[1];
  assign xoff1_o      = flow_q[2];
  assign xoff2_o      = flow_q[3];
  assign auto_cts_en  = feat_q[7];
  assign auto_rts_en  = feat_q[6];
  assign spec_char_en = feat_q[5];
  assign ext_unlock   = feat_q[4];
  assign sw_flow_mode = feat_q[3:0];

  assert_normal_write_spares_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (lcr_o != KEY)) |=> $stable(flow_q));
  assert_feature_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (lcr_o == KEY) && (reg_addr == A_STATUS)) |=> (feat_q == $past(reg_wdata)));
  assert_line_reachable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_LINE)) |=> (lcr_o == $past(reg_wdata)));
  assert_status_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (lcr_o != KEY) && (reg_addr == A_STATUS) && !ext_unlock)
      |=> ((reg_rdata & ISR_XMASK) == '0));
  assert_rdata_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/uart_enh_regfile_test.sv
module uart_enh_regfile_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, isr_in = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_rdata, lcr_o, ier_o, fcr_o, mcr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
  logic auto_cts_en, auto_rts_en, spec_char_en, ext_unlock;
  logic [3:0] sw_flow_mode;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_enh_regfile uut (.*);

  // behavioural reference model
  byte unsigned m_lcr, m_efr, m_ier, m_fcr, m_mcr, m_rd;
  byte unsigned m_fl[4];

  function automatic byte unsigned merge(byte unsigned old, byte unsigned nw, byte unsigned lockm, bit unl);
    return unl ? nw : ((nw & ~lockm) | (old & lockm));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lcr = 0; m_efr = 0; m_ier = 0; m_fcr = 0; m_mcr = 0; m_rd = 0;
      foreach (m_fl[k]) m_fl[k] = 0;
    end else begin
      bit enh, unl;
      int a;
      enh = (m_lcr == 8'hBF);
      unl = m_efr[4];
      a = reg_addr;
      if (reg_rd) begin
        m_rd = 0;
        if (a == 3) m_rd = m_lcr;
        else if (enh) begin
          if (a == 2) m_rd = m_efr;
          else if (a >= 4) m_rd = m_fl[a-4];
        end else begin
          if (a == 1) m_rd = m_ier;
          else if (a == 2) m_rd = unl ? isr_in : (isr_in & 8'hCF);
          else if (a == 4) m_rd = m_mcr;
        end
      end
      if (reg_wr) begin
        if (a == 3) m_lcr = reg_wdata;
        else if (enh) begin
          if (a == 2) m_efr = reg_wdata;
          else if (a >= 4) m_fl[a-4] = reg_wdata;
        end else begin
          if (a == 1) m_ier = merge(m_ier, reg_wdata, 8'hF0, unl);
          else if (a == 2) m_fcr = merge(m_fcr, reg_wdata, 8'h30, unl);
          else if (a == 4) m_mcr = merge(m_mcr, reg_wdata, 8'hE0, unl);
        end
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R3 rdata", reg_rdata, m_rd);
    check("R4 lcr", lcr_o, m_lcr);
    check("R7 ier", ier_o, m_ier);
    check("R8 fcr", fcr_o, m_fcr);
    check("R9 mcr", mcr_o, m_mcr);
    check("R5 xon1", xon1_o, m_fl[0]);
    check("R5 xon2", xon2_o, m_fl[1]);
    check("R5 xoff1", xoff1_o, m_fl[2]);
    check("R5 xoff2", xoff2_o, m_fl[3]);
    check("R6 modes", {auto_cts_en, auto_rts_en, spec_char_en, ext_unlock, sw_flow_mode}, m_efr);
  end

  task automatic wr_reg(int a, byte unsigned d);
    @(negedge clk); reg_addr = 3'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(int a, byte unsigned exp, string tag);
    @(negedge clk); reg_addr = 3'(a); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lcr reset", lcr_o, 8'h00);
    check("R1 rdata reset", reg_rdata, 8'h00);
    check("R1 xon1 reset", xon1_o, 8'h00);
    rst_n = 1;
    // locked extended bits
    wr_reg(1, 8'hFF); check("R7 locked ier", ier_o, 8'h0F);
    wr_reg(2, 8'hFF); check("R8 locked fcr", fcr_o, 8'hCF);
    wr_reg(4, 8'hFF); check("R9 locked mcr", mcr_o, 8'h1F);
    isr_in = 8'hFF;
    rd_reg(2, 8'hCF, "R10 masked isr");
    check("R5 normal fcr write spares feature", {7'b0, ext_unlock}, 8'h00);
    // near-miss key stays in normal map
    wr_reg(3, 8'hBE);
    wr_reg(5, 8'h77); check("R2 near key xon2 unchanged", xon2_o, 8'h00);
    rd_reg(5, 8'h00, "R11 normal addr5 reads zero");
    // enter enhanced map
    wr_reg(3, 8'hBF);
    wr_reg(2, 8'hF5);
    check("R6 cts", {7'b0, auto_cts_en}, 1); check("R6 mode", {4'b0, sw_flow_mode}, 8'h05);
    wr_reg(4, 8'h11); wr_reg(5, 8'h13); wr_reg(6, 8'h19); wr_reg(7, 8'h93);
    rd_reg(2, 8'hF5, "R3 feature readback");
    rd_reg(4, 8'h11, "R3 xon1 readback");
    rd_reg(5, 8'h13, "R3 xon2 readback");
    rd_reg(6, 8'h19, "R3 xoff1 readback");
    rd_reg(7, 8'h93, "R3 xoff2 readback");
    rd_reg(3, 8'hBF, "R4 line in enhanced map");
    rd_reg(1, 8'h00, "R11 enhanced addr1 reads zero");
    wr_reg(1, 8'hAA);
    wr_reg(3, 8'h03);
    rd_reg(1, 8'h0F, "R11 enhanced write ignored by ier");
    // normal map, unlocked
    wr_reg(4, 8'h55); check("R9 unlocked mcr", mcr_o, 8'h55);
    check("R5 xon1 kept", xon1_o, 8'h11);
    wr_reg(1, 8'hFF); check("R7 unlocked ier", ier_o, 8'hFF);
    rd_reg(2, 8'hFF, "R10 unmasked isr");
    // relock
    wr_reg(3, 8'hBF); wr_reg(2, 8'h00); wr_reg(3, 8'h00);
    wr_reg(1, 8'h00); check("R7 relocked ier", ier_o, 8'hF0);
    // random traffic, biased to the key
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reg_addr  = 3'($urandom_range(0, 7));
      reg_wdata = 8'($urandom);
      if (reg_addr == 3 && $urandom_range(0, 1) == 1) reg_wdata = 8'hBF;
      reg_wr = ($urandom_range(0, 2) == 0);
      reg_rd = ($urandom_range(0, 1) == 0);
      isr_in = 8'($urandom);
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    @(negedge clk);
    finish_run();
  end
endmodule